// File: doc/BRIEF.md
# Flag-Based Condition Evaluator

This block decides whether a four-bit condition code holds against the processor status flags: overflow, carry, zero, sign and saturation. One evaluator serves two consumers. A conditional-branch path receives a taken decision and a displacement sign-extended to the data width. A set-flag path receives a data word for a destination register that is exactly 1 when the condition holds and 0 when it does not.

Each request is a single-cycle strobe carrying the code, the flags, the displacement and a mode select. The decision and the formatted data appear on registered outputs on the clock edge that follows the strobe. Fetch, program-counter update and register storage sit outside the block. It only drives the decision, the offset and the write data.

Top module: `flagcond_unit`

## Requirements
- R1: A synchronous active-high reset drives `taken`, `offset`, `wdata` and `wvalid` to zero.
- R2: Codes 0 to 7 hold, in that order, when: overflow is set; carry is set; zero is set; carry or zero is set; sign is set; always; sign XOR overflow is 1; zero is set or sign XOR overflow is 1.
- R3: Each code 8 to 15 other than 13 holds exactly when the code 8 below it does not hold. Code 8 is no overflow, code 10 is not zero, code 14 is sign equal to overflow, and so on.
- R4: Code 5 holds whatever the flags are, and code 13 holds exactly when the saturation flag is set.
- R5: A strobe in branch mode (`mode` = 0) loads `offset` on the next edge with `disp` sign-extended from 9 bits to 32 bits.
- R6: A strobe in set-flag mode (`mode` = 1) raises `wvalid` for one cycle on the next edge. In the same cycle `wdata` is 1 if the condition holds and 0 otherwise, so bits 31 to 1 are always zero.
- R7: `taken` goes high on the edge after a branch-mode strobe whose condition holds, and it is low in every other cycle. `taken` stays low after a set-flag strobe, `wvalid` stays low after a branch-mode strobe, and both are low after a cycle without a strobe.
- R8: `offset` changes only after a branch-mode strobe, and `wdata` changes only after a set-flag strobe. Otherwise both hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe, one cycle per request |
| mode | input | 1 | 0 = branch decision, 1 = set-flag data |
| cond | input | 4 | Condition code |
| flag_ov | input | 1 | Overflow flag |
| flag_cy | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_sat | input | 1 | Saturation flag |
| disp | input | 9 | Signed branch displacement |
| taken | output | 1 | Branch taken, registered |
| offset | output | 32 | Sign-extended displacement, registered |
| wdata | output | 32 | Set-flag result, 0 or 1 |
| wvalid | output | 1 | Set-flag result valid, one-cycle pulse |

## Verification
The output registers are the only state. A wrong decode term or a mis-wired flag shows up on `taken` or `wdata[0]` on the very edge after the first strobe that uses that code with a telling flag pattern. For this reason every code is crossed with all 32 flag patterns in both modes. A bad extension bit or a faulty hold enable corrupts `offset` or `wdata` one cycle after a strobe of the opposite mode or an idle cycle, so strobes are interleaved with idle cycles and mode changes. Each of these is compared on every clock.

// File: rtl/flagcond_pkg.sv
package flagcond_pkg;

   typedef struct packed {
      logic ov;
      logic cy;
      logic z;
      logic s;
      logic sat;
   } flags_t;

   typedef enum logic {
      MODE_BRANCH = 1'b0,
      MODE_SETF   = 1'b1
   } mode_e;

   localparam int unsigned COND_W      = 4;
   localparam int unsigned COND_N      = 1 << COND_W;
   localparam int unsigned COND_HALF   = COND_N / 2;
   localparam int unsigned COND_ALWAYS = 5;
   localparam int unsigned COND_SATSET = 13;

endpackage

// File: rtl/flagcond_decode.sv
module flagcond_decode
   import flagcond_pkg::*;
(
   input  logic [COND_W-1:0] cond,
   input  flags_t            flags,
   output logic              hit
);

   logic [COND_HALF-1:0] base;
   logic [COND_N-1:0]    table_hit;
   logic                 lt_signed;

   assign lt_signed = flags.s ^ flags.ov;

   always_comb begin
      base    = '0;
      base[0] = flags.ov;
      base[1] = flags.cy;
      base[2] = flags.z;
      base[3] = flags.cy | flags.z;
      base[4] = flags.s;
      base[5] = 1'b1;
      base[6] = lt_signed;
      base[7] = flags.z | lt_signed;
   end

   for (genvar gi = 0; gi < COND_N; gi++) begin : g_code
      if (gi == COND_SATSET) begin : g_sat
         assign table_hit[gi] = flags.sat;
      end else if (gi < COND_HALF) begin : g_pos
         assign table_hit[gi] = base[gi];
      end else begin : g_neg
         assign table_hit[gi] = ~base[gi-COND_HALF];
      end
   end

   assign hit = table_hit[cond];

endmodule

// File: rtl/flagcond_sext.sv
module flagcond_sext #(
   parameter int unsigned IN_W  = 9,
   parameter int unsigned OUT_W = 32
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);

   localparam int unsigned PAD_W = OUT_W - IN_W;

   if (IN_W < 2 || IN_W > OUT_W) begin : g_bad_width
      $error("flagcond_sext: IN_W must be between 2 and OUT_W");
   end

   if (PAD_W == 0) begin : g_pass
      assign dout = din;
   end else begin : g_extend
      assign dout = {{PAD_W{din[IN_W-1]}}, din};
   end

endmodule

// File: rtl/flagcond_outreg.sv
module flagcond_outreg #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              sel_setf,
   input  logic              hit,
   input  logic [DATA_W-1:0] ext_disp,
   output logic              taken,
   output logic [DATA_W-1:0] offset,
   output logic [DATA_W-1:0] wdata,
   output logic              wvalid
);

   logic br_req;
   logic sf_req;

   assign br_req = in_valid & ~sel_setf;
   assign sf_req = in_valid & sel_setf;

   always_ff @(posedge clk) begin
      if (rst) begin
         taken  <= 1'b0;
         wvalid <= 1'b0;
         offset <= '0;
         wdata  <= '0;
      end else begin
         taken  <= br_req & hit;
         wvalid <= sf_req;
         if (br_req) begin
            offset <= ext_disp;
         end
         if (sf_req) begin
            wdata <= DATA_W'(hit);
         end
      end
   end

endmodule

// File: rtl/flagcond_unit.sv
module flagcond_unit
   import flagcond_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DISP_W = 9
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic                    mode,
   input  logic [3:0]              cond,
   input  logic                    flag_ov,
   input  logic                    flag_cy,
   input  logic                    flag_z,
   input  logic                    flag_s,
   input  logic                    flag_sat,
   input  logic [DISP_W-1:0]       disp,
   output logic                    taken,
   output logic [DATA_W-1:0]       offset,
   output logic [DATA_W-1:0]       wdata,
   output logic                    wvalid
);

   if (DATA_W < 2) begin : g_bad_data
      $error("flagcond_unit: DATA_W too small");
   end

   flags_t               flags;
   mode_e                mode_q;
   logic                 hit;
   logic [DATA_W-1:0]    ext_disp;

   assign flags  = '{ov: flag_ov, cy: flag_cy, z: flag_z, s: flag_s, sat: flag_sat};
   assign mode_q = mode_e'(mode);

   flagcond_decode u_decode (
      .cond  (cond),
      .flags (flags),
      .hit   (hit)
   );

   flagcond_sext #(
      .IN_W  (DISP_W),
      .OUT_W (DATA_W)
   ) u_sext (
      .din  (disp),
      .dout (ext_disp)
   );

   flagcond_outreg #(
      .DATA_W (DATA_W)
   ) u_outreg (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .sel_setf (mode_q == MODE_SETF),
      .hit      (hit),
      .ext_disp (ext_disp),
      .taken    (taken),
      .offset   (offset),
      .wdata    (wdata),
      .wvalid   (wvalid)
   );

endmodule

// File: rtl/flagcond_chk.sv
module flagcond_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DISP_W = 9
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              mode,
   input logic [3:0]        cond,
   input logic              flag_s,
   input logic              flag_sat,
   input logic [DISP_W-1:0] disp,
   input logic              taken,
   input logic [DATA_W-1:0] offset,
   input logic [DATA_W-1:0] wdata,
   input logic              wvalid
);

   p_always_taken_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !mode && cond == 4'd5) |=> taken);

   p_sat_test_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !mode && cond == 4'd13) |=> (taken == $past(flag_sat)));

   p_sign_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode && cond == 4'd12) |=> (wdata == DATA_W'(!$past(flag_s))));

   p_offset_ext_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !mode) |=> (offset == DATA_W'($signed($past(disp)))));

   p_wvalid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode) |=> wvalid);

   p_wdata_bit_r6: assert property (@(posedge clk) disable iff (rst)
      wvalid |-> (wdata[DATA_W-1:1] == '0));

   p_setf_no_taken_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode) |=> !taken);

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!taken && !wvalid));

   p_offset_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && !mode) |=> $stable(offset));

   p_wdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !(in_valid && mode) |=> $stable(wdata));

endmodule

bind flagcond_unit flagcond_chk #(
   .DATA_W (DATA_W),
   .DISP_W (DISP_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .mode     (mode),
   .cond     (cond),
   .flag_s   (flag_s),
   .flag_sat (flag_sat),
   .disp     (disp),
   .taken    (taken),
   .offset   (offset),
   .wdata    (wdata),
   .wvalid   (wvalid)
);

// File: tb/sim_flagcond_unit.sv
module sim_flagcond_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        mode = 1'b0;
   logic [3:0]  cond = '0;
   logic        flag_ov = 1'b0, flag_cy = 1'b0, flag_z = 1'b0, flag_s = 1'b0, flag_sat = 1'b0;
   logic [8:0]  disp = '0;
   logic        taken;
   logic [31:0] offset;
   logic [31:0] wdata;
   logic        wvalid;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic        e_taken = 1'b0;
   logic        e_wvalid = 1'b0;
   logic [31:0] e_offset = '0;
   logic [31:0] e_wdata = '0;
   string       tag_dec = "R7";
   string       tag_off = "R8";
   string       tag_wd  = "R8";
   string       tag_wv  = "R7";

   always #5 clk = ~clk;

   flagcond_unit u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .cond(cond),
      .flag_ov(flag_ov), .flag_cy(flag_cy), .flag_z(flag_z), .flag_s(flag_s),
      .flag_sat(flag_sat), .disp(disp), .taken(taken), .offset(offset),
      .wdata(wdata), .wvalid(wvalid)
   );

   function automatic bit model_cond(int code, bit ov, bit cy, bit z, bit s, bit sat);
      bit r;
      case (code)
         0:  r = ov;
         1:  r = cy;
         2:  r = z;
         3:  r = cy || z;
         4:  r = s;
         5:  r = 1;
         6:  r = (s != ov);
         7:  r = z || (s != ov);
         8:  r = !ov;
         9:  r = !cy;
         10: r = !z;
         11: r = !(cy || z);
         12: r = !s;
         13: r = sat;
         14: r = (s == ov);
         default: r = !(z || (s != ov));
      endcase
      return r;
   endfunction

   function automatic string code_tag(int code);
      if (code == 5 || code == 13) return "R4";
      if (code < 8) return "R2";
      return "R3";
   endfunction

   task automatic cmp1(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      cmp1(tag_dec, "taken", {31'b0, taken}, {31'b0, e_taken});
      cmp1(tag_wv, "wvalid", {31'b0, wvalid}, {31'b0, e_wvalid});
      cmp1(tag_off, "offset", offset, e_offset);
      cmp1(tag_wd, "wdata", wdata, e_wdata);
   endtask

   // Apply one request (or idle) at a falling edge, after checking the previous one.
   task automatic step(bit v, bit m, int code, int fl, logic [8:0] d);
      bit r;
      @(negedge clk);
      compare_all();
      in_valid = v; mode = m; cond = 4'(code); disp = d;
      flag_ov = fl[4]; flag_cy = fl[3]; flag_z = fl[2]; flag_s = fl[1]; flag_sat = fl[0];
      r = model_cond(code, fl[4], fl[3], fl[2], fl[1], fl[0]);
      e_taken  = v && !m && r;
      e_wvalid = v && m;
      tag_dec  = (v && !m) ? code_tag(code) : "R7";
      tag_wv   = v ? "R6" : "R7";
      if (v && !m) begin
         e_offset = {{23{d[8]}}, d};
         tag_off  = "R5";
      end else begin
         tag_off  = "R8";
      end
      if (v && m) begin
         e_wdata = {31'b0, r};
         tag_wd  = code_tag(code);
      end else begin
         tag_wd  = "R8";
      end
   endtask

   initial begin
      #1500000;
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [8:0] dsel [6];
      dsel[0] = 9'h000; dsel[1] = 9'h0FF; dsel[2] = 9'h100;
      dsel[3] = 9'h1FF; dsel[4] = 9'h001; dsel[5] = 9'h155;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: all outputs zero after reset
      cmp1("R1", "taken", {31'b0, taken}, 32'h0);
      cmp1("R1", "wvalid", {31'b0, wvalid}, 32'h0);
      cmp1("R1", "offset", offset, 32'h0);
      cmp1("R1", "wdata", wdata, 32'h0);
      rst = 1'b0;
      // R2 R3 R4 R5 R6 R7: every code, every flag pattern, both modes
      for (int m = 0; m < 2; m++) begin
         for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 32; f++) begin
               step(1'b1, m[0], c, f, dsel[(c + f) % 6]);
               if ((f % 7) == 3) step(1'b0, m[0], c, f, 9'h0AA);
            end
         end
      end
      // R8: alternating modes and idle cycles keep the other output held
      for (int k = 0; k < 40; k++) begin
         step(1'b1, k[0], k % 16, (k * 11) % 32, dsel[k % 6]);
         step(1'b0, !k[0], (k + 3) % 16, (k * 5) % 32, 9'h1C3);
      end
      // reset in the middle of traffic clears everything again (R1)
      step(1'b1, 1'b1, 5, 0, 9'h1FF);
      @(negedge clk);
      compare_all();
      rst = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      cmp1("R1", "taken", {31'b0, taken}, 32'h0);
      cmp1("R1", "wvalid", {31'b0, wvalid}, 32'h0);
      cmp1("R1", "offset", offset, 32'h0);
      cmp1("R1", "wdata", wdata, 32'h0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule